// File: doc/BRIEF.md
# Rounded-Accumulation Particle Resampler

This block resamples a particle filter's particle set in one sequential pass over a weight memory whose contents need not sum to one. At an accepted start it latches a fixed-point scale factor K (the wanted output particle count divided by the weight total; the divide is done outside). It then reads one weight per cycle and multiplies it by K. Each product is added to a running cumulative sum, and that sum is rounded half-up to an integer. The difference between this rounded value and the one before it is the number of copies the particle receives.

Every particle produces exactly one pair of writes to the index memory and the factor memory, both at the same address. Particles that get one or more copies are stacked upward from address 0. Particles that get none are stacked downward from address N-1, so both lists share one memory without any gap search. The pass takes a fixed number of cycles whatever the weights are. When it ends, a one-cycle done pulse appears, and the two list lengths are held on output ports.

Control is a four-state machine. IDLE waits for start; the IDLE-to-RUN transition is taken on start and clears the cumulative state. RUN issues one weight read per cycle; the RUN-to-DRAIN transition is taken after the read of address N-1. DRAIN waits out the four-stage datapath; the DRAIN-to-FIN transition is taken after four cycles. FIN raises done for one cycle, and the FIN-to-IDLE transition is unconditional.

Top module: `rr_resampler`

## Requirements
- R1: After reset, done, w_rd_en, idx_we and fac_we are low, and rep_count and disc_count are zero.
- R2: In the cycle after a start is accepted in IDLE, weight reads begin with w_rd_en high. One read is issued per cycle at addresses 0, 1, ..., N-1 in order, and then w_rd_en falls.
- R3: The factor of particle j (counting from 1) is round(C_j) - round(C_(j-1)). Here C_j is the sum of weight_i*K over i=1..j, K is k_scale taken as unsigned with K_FRAC fraction bits and latched at start, C_0 = 0, and round(x) = floor(x + 1/2) on the fixed-point value.
- R4: A particle whose factor is non-zero has its index written at the next free address counting up from 0, in particle order.
- R5: A particle whose factor is zero has its index written at the next free address counting down from N-1, in particle order.
- R6: Each particle's factor is written to the factor memory in the same cycle as its index and at the same address (idx_we equals fac_we, and idx_addr equals fac_addr).
- R7: The write for the particle read in cycle c occurs in cycle c+4. done is high for exactly one cycle, N+4 cycles after the first read cycle, and this timing does not depend on the weights.
- R8: From done onward, rep_count holds the number of particles with a non-zero factor and disc_count the number with a zero factor; their sum is N.
- R9: A start asserted while a pass is in progress (RUN, DRAIN or FIN) is ignored and changes neither the writes nor the done timing.
- R10: Each accepted start clears the cumulative sum, the previous rounded value and both list counters, so a repeated pass over the same weights gives identical writes.
- R11: When K times the weight total equals exactly N * 2^K_FRAC, the factors of one pass sum to N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a pass (accepted only in IDLE) |
| k_scale | input | K_W | Scale factor, unsigned, K_FRAC fraction bits |
| done | output | 1 | One-cycle pulse at the end of a pass |
| w_rd_en | output | 1 | Weight memory read enable |
| w_addr | output | AW | Weight memory read address |
| w_data | input | W_W | Weight read data, valid one cycle after the read |
| idx_we | output | 1 | Index memory write enable |
| idx_addr | output | AW | Index memory write address |
| idx_data | output | AW | Particle index written |
| fac_we | output | 1 | Factor memory write enable |
| fac_addr | output | AW | Factor memory write address |
| fac_data | output | AW+1 | Replication factor written (saturates at its maximum) |
| rep_count | output | AW+1 | Entries in the replicated list |
| disc_count | output | AW+1 | Entries in the discarded list |

## Verification
The assertions assume that the weight memory returns data exactly one cycle after a read and that start is a clean synchronous level. They also assume K and the weights are small enough that the cumulative sum never wraps. Under that assumption the two list counters together never exceed N, and each write advances exactly one of them. The bench models the weight memory with a one-cycle registered read. It uses only scale factors for which the rounded total stays at or below N. These include an exact power-of-two split, a single dominant weight, a half-step K that lands on rounding ties, all-zero weights, and pseudo-random weights.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
    // Stages between a weight read and the matching memory writes.
    localparam int unsigned PIPE_LAT = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DRAIN,
        ST_FIN
    } seq_state_t;
endpackage

// File: rtl/rrs_sequencer.sv
module rrs_sequencer
    import rrs_pkg::*;
#(
    parameter int unsigned N_PART = 2048,
    parameter int unsigned AW     = $clog2(N_PART)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          clr,
    output logic          done
);
    localparam int unsigned DW = $clog2(PIPE_LAT) + 1;
    localparam logic [AW-1:0] LAST_ADDR = AW'(N_PART - 1);
    localparam logic [DW-1:0] LAST_WAIT = DW'(PIPE_LAT - 1);

    seq_state_t state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wait_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_RUN;
            ST_RUN:   if (addr_q == LAST_ADDR) state_d = ST_DRAIN;
            ST_DRAIN: if (wait_q == LAST_WAIT) state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_en   = 1'b0;
        clr     = 1'b0;
        done    = 1'b0;
        rd_addr = addr_q;
        unique case (state_q)
            ST_IDLE:  clr   = start;
            ST_RUN:   rd_en = 1'b1;
            ST_DRAIN: ;
            ST_FIN:   done  = 1'b1;
            default:  ;
        endcase
    end

    // read address and drain counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            wait_q <= '0;
        end else begin
            if (state_q == ST_RUN) addr_q <= addr_q + AW'(1);
            else                   addr_q <= '0;
            if (state_q == ST_DRAIN) wait_q <= wait_q + DW'(1);
            else                     wait_q <= '0;
        end
    end
endmodule

// File: rtl/rrs_scale_accum.sv
module rrs_scale_accum #(
    parameter int unsigned AW     = 11,
    parameter int unsigned W_W    = 18,
    parameter int unsigned K_W    = 24,
    parameter int unsigned K_FRAC = 16,
    parameter int unsigned FAC_W  = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [K_W-1:0]   k_in,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    input  logic [W_W-1:0]   w_data,
    output logic             out_vld,
    output logic [AW-1:0]    out_idx,
    output logic [FAC_W-1:0] out_fac
);
    localparam int unsigned PROD_W = W_W + K_W;
    localparam int unsigned ACC_W  = PROD_W + AW + 1;
    localparam logic [ACC_W-1:0] HALF    = ACC_W'(1) << (K_FRAC - 1);
    localparam logic [ACC_W-1:0] FAC_MAX = ACC_W'({FAC_W{1'b1}});

    logic [K_W-1:0]    k_q;
    logic              v1, v2, v3;
    logic [AW-1:0]     i1, i2, i3;
    logic [PROD_W-1:0] prod_q;
    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  prev_q;
    logic [ACC_W-1:0]  rnd;
    logic [ACC_W-1:0]  diff;
    logic [FAC_W-1:0]  fac_sat;

    always_comb begin
        rnd  = (acc_q + HALF) >> K_FRAC;
        diff = rnd - prev_q;
        if (diff > FAC_MAX) fac_sat = {FAC_W{1'b1}};
        else                fac_sat = diff[FAC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_q     <= '0;
            v1      <= 1'b0;
            v2      <= 1'b0;
            v3      <= 1'b0;
            out_vld <= 1'b0;
            i1      <= '0;
            i2      <= '0;
            i3      <= '0;
            out_idx <= '0;
            prod_q  <= '0;
            acc_q   <= '0;
            prev_q  <= '0;
            out_fac <= '0;
        end else begin
            if (clr) k_q <= k_in;
            // stage 1: align with the memory read data
            v1 <= rd_en;
            i1 <= rd_addr;
            // stage 2: scale
            v2 <= v1;
            i2 <= i1;
            if (v1) prod_q <= PROD_W'(w_data) * PROD_W'(k_q);
            // stage 3: accumulate
            v3 <= v2;
            i3 <= i2;
            if (clr)     acc_q <= '0;
            else if (v2) acc_q <= acc_q + ACC_W'(prod_q);
            // stage 4: round and difference
            out_vld <= v3;
            out_idx <= i3;
            if (clr)     prev_q <= '0;
            else if (v3) prev_q <= rnd;
            if (v3) out_fac <= fac_sat;
        end
    end
endmodule

// File: rtl/rrs_index_alloc.sv
module rrs_index_alloc #(
    parameter int unsigned N_PART = 2048,
    parameter int unsigned AW     = $clog2(N_PART),
    parameter int unsigned FAC_W  = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             in_vld,
    input  logic [AW-1:0]    in_idx,
    input  logic [FAC_W-1:0] in_fac,
    output logic             idx_we,
    output logic [AW-1:0]    idx_addr,
    output logic [AW-1:0]    idx_data,
    output logic             fac_we,
    output logic [AW-1:0]    fac_addr,
    output logic [FAC_W-1:0] fac_data,
    output logic [AW:0]      rep_count,
    output logic [AW:0]      disc_count
);
    localparam logic [AW-1:0] TOP = AW'(N_PART - 1);

    logic [AW:0]   up_q, dn_q;
    logic          keep;
    logic [AW-1:0] wr_addr;

    always_comb begin
        keep     = (in_fac != '0);
        wr_addr  = keep ? up_q[AW-1:0] : (TOP - dn_q[AW-1:0]);
        idx_we   = in_vld;
        fac_we   = in_vld;
        idx_addr = wr_addr;
        fac_addr = wr_addr;
        idx_data = in_idx;
        fac_data = in_fac;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_q <= '0;
            dn_q <= '0;
        end else if (clr) begin
            up_q <= '0;
            dn_q <= '0;
        end else if (in_vld) begin
            if (keep) up_q <= up_q + (AW+1)'(1);
            else      dn_q <= dn_q + (AW+1)'(1);
        end
    end

    assign rep_count  = up_q;
    assign disc_count = dn_q;
endmodule

// File: rtl/rr_resampler.sv
module rr_resampler #(
    parameter int unsigned N_PART = 2048,
    parameter int unsigned W_W    = 18,
    parameter int unsigned K_W    = 24,
    parameter int unsigned K_FRAC = 16,
    localparam int unsigned AW    = $clog2(N_PART),
    localparam int unsigned FAC_W = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [K_W-1:0]   k_scale,
    output logic             done,
    output logic             w_rd_en,
    output logic [AW-1:0]    w_addr,
    input  logic [W_W-1:0]   w_data,
    output logic             idx_we,
    output logic [AW-1:0]    idx_addr,
    output logic [AW-1:0]    idx_data,
    output logic             fac_we,
    output logic [AW-1:0]    fac_addr,
    output logic [FAC_W-1:0] fac_data,
    output logic [AW:0]      rep_count,
    output logic [AW:0]      disc_count
);
    logic             clr;
    logic             p_vld;
    logic [AW-1:0]    p_idx;
    logic [FAC_W-1:0] p_fac;

    rrs_sequencer #(.N_PART(N_PART), .AW(AW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .rd_en   (w_rd_en),
        .rd_addr (w_addr),
        .clr     (clr),
        .done    (done)
    );

    rrs_scale_accum #(
        .AW(AW), .W_W(W_W), .K_W(K_W), .K_FRAC(K_FRAC), .FAC_W(FAC_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .k_in    (k_scale),
        .rd_en   (w_rd_en),
        .rd_addr (w_addr),
        .w_data  (w_data),
        .out_vld (p_vld),
        .out_idx (p_idx),
        .out_fac (p_fac)
    );

    rrs_index_alloc #(.N_PART(N_PART), .AW(AW), .FAC_W(FAC_W)) u_alloc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .in_vld     (p_vld),
        .in_idx     (p_idx),
        .in_fac     (p_fac),
        .idx_we     (idx_we),
        .idx_addr   (idx_addr),
        .idx_data   (idx_data),
        .fac_we     (fac_we),
        .fac_addr   (fac_addr),
        .fac_data   (fac_data),
        .rep_count  (rep_count),
        .disc_count (disc_count)
    );
endmodule

// File: rtl/rr_resampler_chk.sv
module rr_resampler_chk #(
    parameter int unsigned N_PART = 2048,
    parameter int unsigned AW     = $clog2(N_PART),
    parameter int unsigned FAC_W  = AW + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done,
    input logic             w_rd_en,
    input logic [AW-1:0]    w_addr,
    input logic             idx_we,
    input logic [AW-1:0]    idx_addr,
    input logic             fac_we,
    input logic [AW-1:0]    fac_addr,
    input logic [FAC_W-1:0] fac_data,
    input logic [AW:0]      rep_count,
    input logic [AW:0]      disc_count
);
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (w_rd_en && $past(w_rd_en)) |-> (w_addr == $past(w_addr) + AW'(1)));

    a_r6_we_pair: assert property (@(posedge clk) disable iff (!rst_n)
        idx_we == fac_we);

    a_r6_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        idx_we |-> (idx_addr == fac_addr));

    a_r4_rep_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_we && fac_data != '0) |=> (rep_count == $past(rep_count) + (AW+1)'(1)));

    a_r5_disc_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_we && fac_data == '0) |=> (disc_count == $past(disc_count) + (AW+1)'(1)));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!idx_we && !w_rd_en));

    a_r8_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rep_count) + 32'(disc_count)) <= N_PART);
endmodule

bind rr_resampler rr_resampler_chk #(.N_PART(N_PART), .AW(AW), .FAC_W(FAC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .w_rd_en    (w_rd_en),
    .w_addr     (w_addr),
    .idx_we     (idx_we),
    .idx_addr   (idx_addr),
    .fac_we     (fac_we),
    .fac_addr   (fac_addr),
    .fac_data   (fac_data),
    .rep_count  (rep_count),
    .disc_count (disc_count)
);

// File: tb/tb_rr_resampler.sv
`timescale 1ns/1ps
module tb_rr_resampler;
    localparam int NP = 16;
    localparam int WW = 18;
    localparam int KW = 24;
    localparam int KF = 16;
    localparam int AW = $clog2(NP);
    localparam int LAT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [KW-1:0] k_scale = '0;
    logic done, w_rd_en, idx_we, fac_we;
    logic [AW-1:0] w_addr, idx_addr, idx_data, fac_addr;
    logic [WW-1:0] w_data;
    logic [AW:0] fac_data, rep_count, disc_count;

    always #4 clk = ~clk;

    rr_resampler #(.N_PART(NP), .W_W(WW), .K_W(KW), .K_FRAC(KF)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .k_scale(k_scale),
        .done(done), .w_rd_en(w_rd_en), .w_addr(w_addr), .w_data(w_data),
        .idx_we(idx_we), .idx_addr(idx_addr), .idx_data(idx_data),
        .fac_we(fac_we), .fac_addr(fac_addr), .fac_data(fac_data),
        .rep_count(rep_count), .disc_count(disc_count));

    // weight memory with one-cycle registered read
    logic [WW-1:0] wmem [NP];
    always_ff @(posedge clk) if (w_rd_en) w_data <= wmem[w_addr];

    typedef struct { int addr; int idx; int fac; } exp_t;
    exp_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    int fac_sum = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: pops the expected write and compares (R3, R4, R5, R6)
    always @(negedge clk) begin
        if (rst_n && idx_we) begin
            if (q.size() == 0) begin
                chk(1'b0, "R7", "write outside a pass", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(int'(idx_data) == e.idx, "R4/R5", "index value", idx_data, e.idx);
                chk(int'(idx_addr) == e.addr, e.fac != 0 ? "R4" : "R5", "index address", idx_addr, e.addr);
                chk(int'(fac_data) == e.fac, "R3", "factor", fac_data, e.fac);
                chk(fac_we && fac_addr == idx_addr, "R6", "factor address", fac_addr, idx_addr);
                fac_sum += int'(fac_data);
            end
        end
    end

    // driver: computes the expected writes, runs a pass, checks timing and counts
    task automatic run_pass(input string name, input longint k, input bit exact, input bit poke);
        longint cum = 0, prv = 0, r;
        int up = 0, dn = 0, cyc;
        bit rd_ok = 1'b1;
        exp_t e;
        for (int j = 0; j < NP; j++) begin
            cum += longint'(wmem[j]) * k;
            r = (cum + (longint'(1) << (KF - 1))) >>> KF;
            e.idx = j;
            e.fac = int'(r - prv);
            prv = r;
            if (e.fac != 0) begin e.addr = up; up++; end
            else begin e.addr = NP - 1 - dn; dn++; end
            q.push_back(e);
        end
        fac_sum = 0;
        @(negedge clk);
        k_scale = KW'(k);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 200) begin
            if (cyc < NP && !(w_rd_en && int'(w_addr) == cyc)) rd_ok = 1'b0;
            if (poke && cyc == 6) start = 1'b1;   // R9: start during RUN
            if (poke && cyc == NP + 1) start = 1'b1; // R9: start during DRAIN
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        chk(rd_ok, "R2", {name, " read sequence"}, rd_ok, 1);
        chk(cyc == NP + LAT, "R7", {name, " done latency"}, cyc, NP + LAT);
        chk(q.size() == 0, "R7", {name, " writes done by done"}, q.size(), 0);
        chk(int'(rep_count) == up, "R8", {name, " rep_count"}, rep_count, up);
        chk(int'(disc_count) == dn, "R8", {name, " disc_count"}, disc_count, dn);
        if (exact) chk(fac_sum == NP, "R11", {name, " factor sum"}, fac_sum, NP);
        @(negedge clk);
        chk(!done && !w_rd_en, "R7", {name, " done one cycle, no restart"}, done, 0);
        q.delete();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "WD", "watchdog expired", 1, 0);
        summary();
    end

    initial begin
        int s;
        logic [15:0] lf;
        for (int i = 0; i < NP; i++) wmem[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!done && !w_rd_en && !idx_we && !fac_we, "R1", "controls low in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !w_rd_en && !idx_we && !fac_we, "R1", "controls low after reset", w_rd_en, 0);
        chk(rep_count == 0 && disc_count == 0, "R1", "counts zero", rep_count, 0);

        // equal weights, K exact: one copy each
        for (int i = 0; i < NP; i++) wmem[i] = 18'd4096;
        run_pass("uniform", 16, 1'b1, 1'b0);

        // single dominant weight: all copies to particle 5
        for (int i = 0; i < NP; i++) wmem[i] = '0;
        wmem[5] = 18'd1000;
        run_pass("single", (longint'(NP) << KF) / 1000, 1'b0, 1'b0);

        // half-step K: every odd cumulative sum is a rounding tie (R3)
        for (int i = 0; i < NP; i++) wmem[i] = 18'd1;
        run_pass("ties", 32768, 1'b0, 1'b0);
        run_pass("ties_again", 32768, 1'b0, 1'b0); // R10

        // all-zero weights: every particle discarded (R5)
        for (int i = 0; i < NP; i++) wmem[i] = '0;
        run_pass("zeros", 65536, 1'b0, 1'b0);

        // pseudo-random weights, with starts poked mid-pass (R9)
        lf = 16'hACE1;
        s = 0;
        for (int i = 0; i < NP; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            wmem[i] = (i % 3 == 0) ? 18'd0 : WW'(lf);
            s += int'(wmem[i]);
        end
        run_pass("random_poke", (longint'(NP) << KF) / s, 1'b0, 1'b1);
        run_pass("random", (longint'(NP) << KF) / s, 1'b0, 1'b0);

        summary();
    end
endmodule